// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block is the control logic that keeps a five-stage integer pipeline (fetch, decode, execute, memory, writeback) correct when instructions overlap. It reads the register numbers, write enables and load/store flags held in the pipeline registers. From these it drives the operand bypass selects for the execute stage and the store-data bypass select for the memory stage. It also raises a stall for fetch and decode, a bubble into execute, and a squash of the fetch and decode contents.

Results are bypassed from the memory stage and from writeback into execute operands. A writeback result can also be steered into the memory stage as store data. That last path lets a store issue directly behind a load of its data without waiting. The register file returns the old value when a register is read and written in the same cycle. Because of this, a decode-stage read of a register being written back is held for one cycle. Branches resolve in execute, so a taken branch squashes the two younger instructions in fetch and decode. The block is purely combinational. Its outputs are meant to be registered by the pipeline around it.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An execute operand whose register equals a writing, non-load memory-stage destination gets select 1 (memory bypass). Select 0 means the register file value.
- R2: An execute operand with no qualifying memory-stage match, but a match on a writing writeback destination, gets select 2 (writeback bypass).
- R3: When both the memory-stage and the writeback destinations match an execute operand, select 1 wins.
- R4: Register 0 never causes a bypass or a stall, whatever the write enables.
- R5: A load in execute whose nonzero destination equals a used source in decode raises stall and bubble for that cycle. For the second source this holds only if decode is not a store.
- R6: A store in decode whose only match against a load in execute is its data source does not stall.
- R7: The store-data select is 1 exactly when the memory stage holds a store and its data register equals a writing, nonzero writeback destination.
- R8: A used decode source equal to a writing, nonzero writeback destination raises stall and bubble.
- R9: A taken branch in execute raises flush and bubble and holds stall low, even when a decode hazard is present.
- R10: A decode source whose used flag is low never causes a stall.
- R11: A load in the memory stage is never bypassed to execute. The writeback match then applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | decode first source register |
| id_rt | input | REG_W | decode second source register |
| id_rs_used | input | 1 | decode reads its first source |
| id_rt_used | input | 1 | decode reads its second source |
| id_store | input | 1 | decode is a store (second source is store data) |
| ex_rs | input | REG_W | execute first source register |
| ex_rt | input | REG_W | execute second source register |
| ex_dst | input | REG_W | execute destination register |
| ex_wen | input | 1 | execute instruction writes a register |
| ex_load | input | 1 | execute instruction is a load |
| ex_taken | input | 1 | branch in execute resolved taken |
| mem_dst | input | REG_W | memory-stage destination register |
| mem_wen | input | 1 | memory-stage instruction writes a register |
| mem_load | input | 1 | memory-stage instruction is a load |
| mem_store | input | 1 | memory-stage instruction is a store |
| mem_rt | input | REG_W | memory-stage store data register |
| wb_dst | input | REG_W | writeback destination register |
| wb_wen | input | 1 | writeback instruction writes a register |
| ex_a_sel | output | 2 | first execute operand select: 0 file, 1 memory, 2 writeback |
| ex_b_sel | output | 2 | second execute operand select, same encoding |
| mem_sd_sel | output | 1 | store data from writeback when 1 |
| stall_fd | output | 1 | hold program counter and decode register |
| bubble_ex | output | 1 | load a no-op into execute |
| flush_fd | output | 1 | squash fetch and decode contents |

## Verification
The unit holds no state, so any wrong decision shows at the ports in the same cycle as the inputs that cause it. A bad select or a missing stall shows as a wrong select code or control bit. The bench places each hazard and its near misses one at a time. These include register 0, unused sources, a store's data source, and a load in the memory stage. It then reads all six outputs against values worked out from the requirements.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic             id_store,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic             ex_taken,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic             mem_store,
  input  logic [REG_W-1:0] mem_rt,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       ex_a_sel,
  output logic [1:0]       ex_b_sel,
  output logic             mem_sd_sel,
  output logic             stall_fd,
  output logic             bubble_ex,
  output logic             flush_fd
);

  localparam logic [REG_W-1:0] ZERO    = '0;
  localparam logic [1:0]       SEL_RF  = 2'd0;
  localparam logic [1:0]       SEL_MEM = 2'd1;
  localparam logic [1:0]       SEL_WB  = 2'd2;

  always_comb begin : decide
    logic mem_fw, wb_fw, ld_hit, wb_hit;
    mem_fw = mem_wen && !mem_load && (mem_dst != ZERO);
    wb_fw  = wb_wen && (wb_dst != ZERO);

    if (mem_fw && mem_dst == ex_rs)     ex_a_sel = SEL_MEM;
    else if (wb_fw && wb_dst == ex_rs)  ex_a_sel = SEL_WB;
    else                                ex_a_sel = SEL_RF;

    if (mem_fw && mem_dst == ex_rt)     ex_b_sel = SEL_MEM;
    else if (wb_fw && wb_dst == ex_rt)  ex_b_sel = SEL_WB;
    else                                ex_b_sel = SEL_RF;

    mem_sd_sel = mem_store && wb_fw && (wb_dst == mem_rt);

    ld_hit = ex_load && ex_wen && (ex_dst != ZERO) &&
             ((id_rs_used && id_rs == ex_dst) ||
              (id_rt_used && !id_store && id_rt == ex_dst));
    wb_hit = wb_fw && ((id_rs_used && id_rs == wb_dst) ||
                       (id_rt_used && id_rt == wb_dst));

    flush_fd  = ex_taken;
    bubble_ex = ex_taken || ld_hit || wb_hit;
    stall_fd  = !ex_taken && (ld_hit || wb_hit);

    p_flush_excl_r9: assert (!(stall_fd && flush_fd))
      else $error("stall and flush together");
    p_stall_bubble_r5: assert (!stall_fd || bubble_ex)
      else $error("stall without bubble");
    p_stall_cause_r8: assert (!stall_fd || (ex_load && ex_wen) || wb_wen)
      else $error("stall without a writer");
    p_zero_a_r4: assert (ex_rs != ZERO || ex_a_sel == SEL_RF)
      else $error("register 0 bypassed on operand a");
    p_zero_b_r4: assert (ex_rt != ZERO || ex_b_sel == SEL_RF)
      else $error("register 0 bypassed on operand b");
    p_sd_store_r7: assert (!mem_sd_sel || mem_store)
      else $error("store data bypass without a store");
    p_load_nofw_r11: assert (!(mem_load && ex_a_sel == SEL_MEM))
      else $error("load bypassed from memory stage");
  end

endmodule

// File: tb/test_fwd_hazard_unit.sv
module test_fwd_hazard_unit;
  logic       clk = 1'b0;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_rt, wb_dst;
  logic       id_rs_used, id_rt_used, id_store, ex_wen, ex_load, ex_taken;
  logic       mem_wen, mem_load, mem_store, wb_wen;
  logic [1:0] ex_a_sel, ex_b_sel;
  logic       mem_sd_sel, stall_fd, bubble_ex, flush_fd;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fwd_hazard_unit #(.REG_W(5)) i_fwd_hazard_unit (
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
    .id_store(id_store), .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst),
    .ex_wen(ex_wen), .ex_load(ex_load), .ex_taken(ex_taken), .mem_dst(mem_dst),
    .mem_wen(mem_wen), .mem_load(mem_load), .mem_store(mem_store), .mem_rt(mem_rt),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .ex_a_sel(ex_a_sel), .ex_b_sel(ex_b_sel),
    .mem_sd_sel(mem_sd_sel), .stall_fd(stall_fd), .bubble_ex(bubble_ex),
    .flush_fd(flush_fd));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear();
    @(posedge clk);
    id_rs = 5'd1; id_rt = 5'd2; id_rs_used = 1'b1; id_rt_used = 1'b1; id_store = 1'b0;
    ex_rs = 5'd3; ex_rt = 5'd4; ex_dst = 5'd10; ex_wen = 1'b0; ex_load = 1'b0;
    ex_taken = 1'b0; mem_dst = 5'd11; mem_wen = 1'b0; mem_load = 1'b0;
    mem_store = 1'b0; mem_rt = 5'd12; wb_dst = 5'd13; wb_wen = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_idle();
    clear(); settle();
    chk("R1", "idle a_sel", ex_a_sel, 0);
    chk("R2", "idle b_sel", ex_b_sel, 0);
    chk("R7", "idle sd_sel", mem_sd_sel, 0);
    chk("R5", "idle stall", stall_fd, 0);
    chk("R5", "idle bubble", bubble_ex, 0);
    chk("R9", "idle flush", flush_fd, 0);
  endtask

  task automatic t_mem_bypass();
    clear(); mem_dst = 5'd5; mem_wen = 1'b1; ex_rs = 5'd5; ex_rt = 5'd7; settle();
    chk("R1", "a from memory", ex_a_sel, 1);
    chk("R1", "b untouched", ex_b_sel, 0);
    mem_wen = 1'b0; settle();
    chk("R1", "no write no bypass", ex_a_sel, 0);
  endtask

  task automatic t_wb_bypass();
    clear(); wb_dst = 5'd7; wb_wen = 1'b1; ex_rt = 5'd7; ex_rs = 5'd8;
    id_rs_used = 1'b0; id_rt_used = 1'b0; settle();
    chk("R2", "b from writeback", ex_b_sel, 2);
    chk("R2", "a untouched", ex_a_sel, 0);
  endtask

  task automatic t_priority();
    clear(); mem_dst = 5'd3; mem_wen = 1'b1; wb_dst = 5'd3; wb_wen = 1'b1;
    ex_rs = 5'd3; ex_rt = 5'd3; settle();
    chk("R3", "a prefers memory", ex_a_sel, 1);
    chk("R3", "b prefers memory", ex_b_sel, 1);
  endtask

  task automatic t_zero();
    clear(); mem_dst = 5'd0; mem_wen = 1'b1; wb_dst = 5'd0; wb_wen = 1'b1;
    ex_rs = 5'd0; ex_rt = 5'd0; ex_dst = 5'd0; ex_load = 1'b1; ex_wen = 1'b1;
    id_rs = 5'd0; id_rt = 5'd0; settle();
    chk("R4", "zero a", ex_a_sel, 0);
    chk("R4", "zero b", ex_b_sel, 0);
    chk("R4", "zero no stall", stall_fd, 0);
    chk("R4", "zero no bubble", bubble_ex, 0);
  endtask

  task automatic t_load_use();
    clear(); ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd9; id_rs = 5'd9; settle();
    chk("R5", "load use rs stall", stall_fd, 1);
    chk("R5", "load use rs bubble", bubble_ex, 1);
    id_rs = 5'd1; id_rt = 5'd9; settle();
    chk("R5", "load use rt stall", stall_fd, 1);
  endtask

  task automatic t_store_exempt();
    clear(); ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd9; id_store = 1'b1;
    id_rt = 5'd9; settle();
    chk("R6", "store data no stall", stall_fd, 0);
    chk("R6", "store data no bubble", bubble_ex, 0);
    id_rs = 5'd9; settle();
    chk("R6", "store address still stalls", stall_fd, 1);
  endtask

  task automatic t_store_bypass();
    clear(); mem_store = 1'b1; mem_rt = 5'd4; wb_dst = 5'd4; wb_wen = 1'b1; settle();
    chk("R7", "store data from writeback", mem_sd_sel, 1);
    wb_wen = 1'b0; settle();
    chk("R7", "no write no store bypass", mem_sd_sel, 0);
    wb_wen = 1'b1; mem_store = 1'b0; settle();
    chk("R7", "not a store", mem_sd_sel, 0);
    mem_store = 1'b1; mem_rt = 5'd0; wb_dst = 5'd0; settle();
    chk("R7", "register 0 store", mem_sd_sel, 0);
  endtask

  task automatic t_wb_decode();
    clear(); wb_dst = 5'd6; wb_wen = 1'b1; id_rt = 5'd6; id_store = 1'b1; settle();
    chk("R8", "writeback-decode stall", stall_fd, 1);
    chk("R8", "writeback-decode bubble", bubble_ex, 1);
  endtask

  task automatic t_branch();
    clear(); ex_taken = 1'b1; ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd9;
    id_rs = 5'd9; settle();
    chk("R9", "flush", flush_fd, 1);
    chk("R9", "bubble", bubble_ex, 1);
    chk("R9", "no stall on flush", stall_fd, 0);
  endtask

  task automatic t_unused();
    clear(); ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd9; id_rs = 5'd9; id_rt = 5'd9;
    id_rs_used = 1'b0; id_rt_used = 1'b0; wb_dst = 5'd9; wb_wen = 1'b1; settle();
    chk("R10", "unused no stall", stall_fd, 0);
    chk("R10", "unused no bubble", bubble_ex, 0);
  endtask

  task automatic t_mem_load();
    clear(); mem_load = 1'b1; mem_wen = 1'b1; mem_dst = 5'd5; ex_rs = 5'd5;
    wb_dst = 5'd5; wb_wen = 1'b1; id_rs_used = 1'b0; id_rt_used = 1'b0; settle();
    chk("R11", "load in memory falls to writeback", ex_a_sel, 2);
    wb_wen = 1'b0; settle();
    chk("R11", "load in memory not bypassed", ex_a_sel, 0);
  endtask

  initial begin
    t_idle(); t_mem_bypass(); t_wb_bypass(); t_priority(); t_zero(); t_load_use();
    t_store_exempt(); t_store_bypass(); t_wb_decode(); t_branch(); t_unused();
    t_mem_load();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule